// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block collects eight event sources from a telephone line-interface controller into one byte of sticky status flags. Each flag is set by its detector and stays set until software writes a zero to its bit. A per-flag mask and a global enable together decide whether any pending flag drives a single registered, active-high interrupt output.

Some sources are single-cycle pulses. Others are levels, turned into one event per occurrence by an edge detector. The ring source can latch only on the start of a ring pulse, or on both its start and its end. The frame source latches for as long as frame lock is missing. The loop-current source fires when a current-sense value saturates at all ones. A companion receive-overload status flag is set together with the overload flag, and it is cleared whenever the overload flag is cleared.

Software reaches the block through a small bus with one address, one write strobe, write data and combinational read data. Reads never change state.

Top module: `line_irq_status`

## Requirements
- R1: After reset, the status byte, the mask byte, the control byte, the overload status and the `irq` output are all zero.
- R2: A status flag, once set, stays set until a write to address 0 carries a 0 in that bit position. Writing a 1 leaves the flag unchanged.
- R3: When a source event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: `irq` is registered. One clock after the status, mask or control byte changes, `irq` equals the OR over all bits of (status AND mask), gated by the global enable, which is control bit 0.
- R5: Control bit 1 selects the ring edge mode. When it is 0, the ring flag latches only on a rising `ring_active`. When it is 1, the ring flag latches on both the rising and the falling edge.
- R6: The level sources `rx_overload` and `supply_drop` set their flag once per rising edge. A source that stays high does not set the flag again after it has been cleared.
- R7: The frame flag is forced set in every cycle in which `frame_locked` is low, so a clearing write has no effect while lock is missing.
- R8: The loop-current flag sets once when `lcs_value` reaches all ones (LCS_W bits). Any lower value does not set it.
- R9: The overload status, read at address 3 bit 0, sets together with the overload flag. It clears when a write to address 0 clears bit 6, and no other write clears it.
- R10: The status bit order, MSB first, is: bit 7 ring, bit 6 receive overload, bit 5 frame loss, bit 4 billing tone, bit 3 supply dropout, bit 2 loop-current saturation, bit 1 loop-current change, bit 0 polarity change.
- R11: Addresses are 0 status, 1 mask, 2 control (bit 0 enable, bit 1 ring mode) and 3 overload status. The mask and control registers read back what was written. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_active | input | 1 | Ring pulse level |
| rx_overload | input | 1 | Receive overload level |
| frame_locked | input | 1 | High while the link holds frame lock |
| billing_tone | input | 1 | Single-cycle billing tone event |
| supply_drop | input | 1 | Line-side supply collapse level |
| lcs_value | input | LCS_W | Loop-current-sense value |
| lcs_change | input | 1 | Single-cycle loop-current change event |
| polarity_flip | input | 1 | Single-cycle polarity change event |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
A flag latched in error appears at once as an unexpected bit on a status read. It reaches `irq` one clock later if that flag is unmasked. A lost clear, or a stale edge-detector history, shows on the read that follows the write: the flag survives, or it reappears without a fresh edge. A broken link between the overload flag and its status bit shows on the address 3 read right after the clearing write. A wrong gate term in the interrupt path shows on `irq` exactly one clock after the mask or enable write.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  localparam int NSRC = 8;
  localparam int B_RING = 7;
  localparam int B_ROVL = 6;
  localparam int B_FRAME = 5;
  localparam int B_BILL = 4;
  localparam int B_DROP = 3;
  localparam int B_LCSAT = 2;
  localparam int B_LCCHG = 1;
  localparam int B_POL = 0;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_CTRL   = 2'd2,
    A_OVL    = 2'd3
  } reg_addr_e;

  // Interrupt request term: any unmasked pending flag, gated by enable.
  function automatic logic irq_term(input logic [NSRC-1:0] stat,
                                    input logic [NSRC-1:0] mask,
                                    input logic en);
    return en & (|(stat & mask));
  endfunction

  // Flags to clear for a status write: every zero in the write data.
  function automatic logic [NSRC-1:0] clear_vec(input logic wr,
                                                input logic [NSRC-1:0] d);
    return wr ? ~d : '0;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] both_en,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    logic rise, fall;
    assign rise = lvl[i] & ~prev_q[i];
    assign fall = ~lvl[i] & prev_q[i];
    assign evt[i] = rise | (both_en[i] & fall);
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_vec[i]) q[i] <= 1'b1;
      else if (clr_vec[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import line_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  input  logic [NSRC-1:0] stat,
  input  logic            ovl_stat,
  output logic [NSRC-1:0] mask_q,
  output logic            en_q,
  output logic            ring_both_q,
  output logic            stat_wr,
  output logic [7:0]      bus_rdata
);
  reg_addr_e addr;
  assign addr    = reg_addr_e'(bus_addr);
  assign stat_wr = bus_wr && (addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      en_q        <= 1'b0;
      ring_both_q <= 1'b0;
    end else if (bus_wr) begin
      if (addr == A_MASK) mask_q <= bus_wdata[NSRC-1:0];
      if (addr == A_CTRL) begin
        en_q        <= bus_wdata[0];
        ring_both_q <= bus_wdata[1];
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_STATUS: bus_rdata = stat;
      A_MASK:   bus_rdata = mask_q;
      A_CTRL:   bus_rdata = {6'd0, ring_both_q, en_q};
      A_OVL:    bus_rdata = {7'd0, ovl_stat};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/line_irq_status.sv
module line_irq_status
  import line_irq_pkg::*;
#(
  parameter int LCS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_active,
  input  logic             rx_overload,
  input  logic             frame_locked,
  input  logic             billing_tone,
  input  logic             supply_drop,
  input  logic [LCS_W-1:0] lcs_value,
  input  logic             lcs_change,
  input  logic             polarity_flip,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq
);
  localparam int NLVL = 4;

  // Named internal events, also observed by the checker.
  logic [NSRC-1:0] evt_vec, clr_vec, stat;
  logic [NSRC-1:0] mask_q;
  logic            en_q, ring_both_q, stat_wr;
  logic            lcs_sat, ovl_stat;
  logic [NLVL-1:0] lvl_in, lvl_both, lvl_evt;

  assign lcs_sat  = &lcs_value;
  assign lvl_in   = {ring_active, rx_overload, supply_drop, lcs_sat};
  assign lvl_both = {ring_both_q, 3'b000};

  irq_edge_det #(.W(NLVL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_in), .both_en(lvl_both), .evt(lvl_evt)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[B_RING]  = lvl_evt[3];
    evt_vec[B_ROVL]  = lvl_evt[2];
    evt_vec[B_FRAME] = ~frame_locked;
    evt_vec[B_BILL]  = billing_tone;
    evt_vec[B_DROP]  = lvl_evt[1];
    evt_vec[B_LCSAT] = lvl_evt[0];
    evt_vec[B_LCCHG] = lcs_change;
    evt_vec[B_POL]   = polarity_flip;
  end

  assign clr_vec = clear_vec(stat_wr, bus_wdata[NSRC-1:0]);

  irq_sticky_bank #(.W(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_vec), .clr_vec(clr_vec), .q(stat)
  );

  // Companion overload status, tied to the clear of the overload flag.
  irq_sticky_bank #(.W(1)) u_ovl (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_vec[B_ROVL]),
    .clr_vec(clr_vec[B_ROVL]), .q(ovl_stat)
  );

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .stat(stat), .ovl_stat(ovl_stat),
    .mask_q(mask_q), .en_q(en_q), .ring_both_q(ring_both_q),
    .stat_wr(stat_wr), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_term(stat, mask_q, en_q);
  end
endmodule

// File: rtl/line_irq_checker.sv
module line_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stat,
  input logic [7:0] mask_q,
  input logic       en_q,
  input logic       irq,
  input logic [7:0] evt_vec,
  input logic       stat_wr,
  input logic [7:0] bus_wdata,
  input logic       ovl_stat,
  input logic       frame_locked
);
  p_clear_needs_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~stat) != 8'd0) |->
      ($past(stat_wr) && ((($past(stat) & ~stat) & $past(bus_wdata)) == 8'd0)));

  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != 8'd0) |=> ((stat & $past(evt_vec)) == $past(evt_vec)));

  p_irq_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(en_q) && (($past(stat) & $past(mask_q)) != 8'd0))));

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_locked |=> stat[5]);

  p_ovl_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[6]) |-> !ovl_stat);

  p_ovl_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_stat) |-> stat[6]);
endmodule

bind line_irq_status line_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stat(stat), .mask_q(mask_q), .en_q(en_q),
  .irq(irq), .evt_vec(evt_vec), .stat_wr(stat_wr), .bus_wdata(bus_wdata),
  .ovl_stat(ovl_stat), .frame_locked(frame_locked)
);

// File: tb/line_irq_status_bench.sv
`timescale 1ns/1ps
module line_irq_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ring_active = 0, rx_overload = 0, frame_locked = 1;
  logic       billing_tone = 0, supply_drop = 0, lcs_change = 0, polarity_flip = 0;
  logic [7:0] lcs_value = 8'd0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  line_irq_status u_line_irq_status (
    .clk(clk), .rst_n(rst_n), .ring_active(ring_active), .rx_overload(rx_overload),
    .frame_locked(frame_locked), .billing_tone(billing_tone), .supply_drop(supply_drop),
    .lcs_value(lcs_value), .lcs_change(lcs_change), .polarity_flip(polarity_flip),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk_reg("R1 status", 2'd0, 8'h00);
    chk_reg("R1 mask", 2'd1, 8'h00);
    chk_reg("R1 control", 2'd2, 8'h00);
    chk_reg("R1 ovl", 2'd3, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pulse_map();
    billing_tone = 1; step(); billing_tone = 0;
    chk_reg("R10 billing bit4", 2'd0, 8'h10);
    lcs_change = 1; step(); lcs_change = 0;
    polarity_flip = 1; step(); polarity_flip = 0;
    chk_reg("R10 change bit1 polarity bit0", 2'd0, 8'h13);
    wr(2'd0, 8'hFF);
    chk_reg("R2 write ones keeps flags", 2'd0, 8'h13);
    wr(2'd0, 8'hEF);
    chk_reg("R2 clear bit4 only", 2'd0, 8'h03);
    chk_reg("R11 read has no side effect", 2'd0, 8'h03);
    wr(2'd0, 8'h00);
    chk_reg("R2 clear all", 2'd0, 8'h00);
  endtask

  task automatic t_event_wins();
    billing_tone = 1; bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1;
    step();
    billing_tone = 0; bus_wr = 0;
    chk_reg("R3 event beats clear", 2'd0, 8'h10);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_level();
    supply_drop = 1; step();
    chk_reg("R6 dropout bit3", 2'd0, 8'h08);
    wr(2'd0, 8'h00); step();
    chk_reg("R6 held level no re-set", 2'd0, 8'h00);
    supply_drop = 0; step(); supply_drop = 1; step();
    chk_reg("R6 new occurrence sets", 2'd0, 8'h08);
    supply_drop = 0; wr(2'd0, 8'h00);
  endtask

  task automatic t_lcs();
    lcs_value = 8'hFE; step(); step();
    chk_reg("R8 below max", 2'd0, 8'h00);
    lcs_value = 8'hFF; step();
    chk_reg("R8 saturation bit2", 2'd0, 8'h04);
    wr(2'd0, 8'h00); step();
    chk_reg("R8 held saturation once", 2'd0, 8'h00);
    lcs_value = 8'h00; step();
  endtask

  task automatic t_ring();
    ring_active = 1; step();
    chk_reg("R5 rise mode0", 2'd0, 8'h80);
    wr(2'd0, 8'h00);
    ring_active = 0; step();
    chk_reg("R5 fall ignored mode0", 2'd0, 8'h00);
    wr(2'd2, 8'h02);
    chk_reg("R11 control readback", 2'd2, 8'h02);
    ring_active = 1; step();
    wr(2'd0, 8'h00);
    ring_active = 0; step();
    chk_reg("R5 fall latches mode1", 2'd0, 8'h80);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_ovl();
    rx_overload = 1; step();
    chk_reg("R9 flag set", 2'd0, 8'h40);
    chk_reg("R9 status set", 2'd3, 8'h01);
    wr(2'd0, 8'hFF);
    chk_reg("R9 ones write keeps status", 2'd3, 8'h01);
    wr(2'd0, 8'h00);
    chk_reg("R9 status cleared with flag", 2'd3, 8'h00);
    chk_reg("R9 flag cleared", 2'd0, 8'h00);
    rx_overload = 0; step();
  endtask

  task automatic t_frame();
    frame_locked = 0; step();
    chk_reg("R7 loss sets bit5", 2'd0, 8'h20);
    wr(2'd0, 8'h00);
    chk_reg("R7 clear ignored while unlocked", 2'd0, 8'h20);
    frame_locked = 1; wr(2'd0, 8'h00);
    chk_reg("R7 clear after lock", 2'd0, 8'h00);
  endtask

  task automatic t_irq();
    wr(2'd1, 8'h10);
    chk_reg("R11 mask readback", 2'd1, 8'h10);
    wr(2'd2, 8'h01);
    billing_tone = 1; step(); billing_tone = 0;
    chk("R4 irq one clock late", {7'd0, irq}, 8'h00);
    step();
    chk("R4 irq asserted", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    chk("R4 irq holds one clock", {7'd0, irq}, 8'h01);
    step();
    chk("R4 enable off drops irq", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h01); wr(2'd1, 8'h01); step(); step();
    chk("R4 masked flag no irq", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse_map();
    t_event_wins();
    t_level();
    t_lcs();
    t_ring();
    t_ovl();
    t_frame();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule